// File: doc/BRIEF.md
# Fixed-Priority Nested Interrupt Controller

This block gathers interrupt requests from fourteen sources and hands them to a CPU one at a time, always the most urgent first. There are seven external pins: a power-monitor pin and six general interrupt pins. There are also seven internal pulse sources: three serial-port completion events and four timer events. Each source has its own pending latch. The controller picks among the latched requests by a fixed order and offers the winner as a source index on a valid/ready channel. The CPU takes the request by raising ready.

The controller keeps a stack of the levels now in service, so a handler can be interrupted only by a request of strictly higher priority. The CPU pulses a return strobe when a handler ends. The strobe pops the stack and lower-priority work becomes eligible again. Enables and edge selects are loaded together by a plain configuration strobe. The CPU itself, vector fetch and context saving are outside this block.

The request channel follows the usual stream rules. Once `irq_valid_o` is high, it and `irq_idx_o` stay unchanged until the cycle in which `irq_ready_i` is also high. A higher-priority request that arrives in the meantime waits for the next offer. The CPU may hold ready low for as long as it likes.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Sources are numbered 0 to 13 in falling priority. Index 0 is the power-monitor pin (ext_pin_i[0]). Indices 1..6 are the general pins ext_pin_i[1..6]. Indices 7..9 are serial ports 0..2 (intl_evt_i[0..2]). Indices 10..13 are timers 0..3 (intl_evt_i[3..6]). Among the eligible pending sources, the lowest index is offered.
- R2: General pin g (index g, 1..6) latches on a rising edge when cfg_rise_i[g-1] was loaded as 1, and on a falling edge when it was loaded as 0. The opposite edge is ignored.
- R3: The power-monitor pin latches only on a falling edge. Its rising edge never sets its pending bit.
- R4: A pending bit is set only if that source's enable bit is 1 when the edge or pulse arrives. The enable bits and edge selects are loaded from cfg_en_i and cfg_rise_i on a cycle with cfg_wr_i high, and they apply from the next cycle on.
- R5: A level change on an external pin shows in pend_o after the third rising clock edge that follows it. An internal pulse that is high at a clock edge shows in pend_o after that same edge.
- R6: A pending, enabled source is offered only if its index is strictly lower than the level in service. That level is the top of the nesting stack, or 14 when the stack is empty. An accepted request pushes its index, and rti_i pops one entry. A return strobe on an empty stack is ignored.
- R7: irq_valid_o rises one cycle after a source becomes eligible while no offer is open. irq_valid_o and irq_idx_o hold until acceptance (valid and ready both high). Acceptance clears that source's pending bit, but a new event for the same source in the same cycle keeps it set. irq_valid_o is low in the cycle after an acceptance.
- R8: Reset clears all pending bits, enables, edge selects, the nesting stack and the offer.
- R9: The stack holds fourteen levels, so one handler for every source can be nested at once. It never grows past fourteen entries.
- R10: If an acceptance and a return strobe happen in the same cycle, the accepted index replaces the top entry and the depth is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Load strobe for enables and edge selects |
| cfg_en_i | input | 14 | Per-source enable bits, indexed by source number |
| cfg_rise_i | input | 6 | Edge select of general pins 1..6 (1 = rising, 0 = falling) |
| ext_pin_i | input | 7 | Raw external pin levels; bit 0 is the power-monitor pin |
| intl_evt_i | input | 7 | Internal single-cycle events: serial 0..2 then timer 0..3 |
| rti_i | input | 1 | Return-from-interrupt strobe |
| irq_valid_o | output | 1 | Interrupt offer valid |
| irq_idx_o | output | 4 | Source index of the offer |
| irq_ready_i | input | 1 | CPU accepts the offer |
| pend_o | output | 14 | Pending latches, indexed by source number |

## Verification
The hardest state to reach from the ports is a full nesting stack of fourteen levels. Getting there needs one accepted request from every source, in strictly rising priority order. Each must arrive while the one below it is still in service, and the external ones must pass through the synchronizer with the right edge polarity. The bench resets the block, sets every general pin to rising-edge mode, then fires the timer and serial events from lowest to highest and then the pins from pin 6 down to the power-monitor pin, accepting each one. At full depth it checks that no request is offered even with everything pending, and that unwinding the stack lets them through again in order. A cycle-exact reference model, run under random events, ready, return strobes and reconfiguration, covers the other interleavings.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  // Default counts of the source groups
  localparam int GP_PINS_DEF  = 6;
  localparam int INTL_SRC_DEF = 7;

  // Source numbering; a lower value wins arbitration
  typedef enum logic [3:0] {
    SRC_PWR  = 4'd0,
    SRC_GP0  = 4'd1,
    SRC_GP1  = 4'd2,
    SRC_GP2  = 4'd3,
    SRC_GP3  = 4'd4,
    SRC_GP4  = 4'd5,
    SRC_GP5  = 4'd6,
    SRC_SER0 = 4'd7,
    SRC_SER1 = 4'd8,
    SRC_SER2 = 4'd9,
    SRC_TMR0 = 4'd10,
    SRC_TMR1 = 4'd11,
    SRC_TMR2 = 4'd12,
    SRC_TMR3 = 4'd13
  } irq_src_e;

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int N_GP  = irq_nest_pkg::GP_PINS_DEF,
  localparam int N_EXT = N_GP + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] pin_i,
  input  logic [N_GP-1:0]  rise_sel_i,
  output logic [N_EXT-1:0] edge_o
);

  // Two synchronizing stages plus one history stage per pin
  logic [N_EXT-1:0] meta_q, sync_q, hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  for (genvar g = 0; g < N_EXT; g++) begin : g_pin
    if (g == 0) begin : g_pwr
      // power-monitor pin: falling edge only (R3)
      assign edge_o[g] = hist_q[g] & ~sync_q[g];
    end else begin : g_gp
      logic rise_det, fall_det;
      assign rise_det  = sync_q[g] & ~hist_q[g];
      assign fall_det  = hist_q[g] & ~sync_q[g];
      assign edge_o[g] = rise_sel_i[g-1] ? rise_det : fall_det;
    end
  end

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N_SRC = 14,
  localparam int IDX_W = $clog2(N_SRC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             clr_vld_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  output logic [N_SRC-1:0] pend_o
);

  logic [N_SRC-1:0] pend_q, clr_mask;

  for (genvar i = 0; i < N_SRC; i++) begin : g_clr
    assign clr_mask[i] = clr_vld_i && (clr_idx_i == IDX_W'(i));
  end

  // a fresh event in the acceptance cycle survives the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_mask) | (set_i & en_i);
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_issue.sv
module irq_issue #(
  parameter int N_SRC = 14,
  localparam int IDX_W = $clog2(N_SRC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [IDX_W-1:0] lvl_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             accept_o
);

  logic [N_SRC-1:0] cand;
  logic [IDX_W-1:0] best;
  logic             any;
  logic             valid_q;
  logic [IDX_W-1:0] idx_q;

  // eligible: pending, enabled and strictly above the level in service
  for (genvar i = 0; i < N_SRC; i++) begin : g_cand
    assign cand[i] = pend_i[i] & en_i[i] & (IDX_W'(i) < lvl_i);
  end

  // fixed priority: the lowest index wins
  always_comb begin
    best = '0;
    any  = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        best = IDX_W'(i);
        any  = 1'b1;
      end
    end
  end

  assign accept_o = valid_q & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (!valid_q) begin
      valid_q <= any;
      idx_q   <= best;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign idx_o   = idx_q;

endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int N_SRC    = 14,
  parameter int NEST_MAX = 14,
  localparam int IDX_W = $clog2(N_SRC + 1),
  localparam int DW    = $clog2(NEST_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [IDX_W-1:0] push_idx_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] lvl_o,
  output logic [DW-1:0]    depth_o
);

  logic [IDX_W-1:0] stk_q [NEST_MAX];
  logic [DW-1:0]    sp_q, sp_d, wr_ptr;
  logic             do_pop, do_wr;

  assign do_pop = pop_i && (sp_q != '0);
  assign wr_ptr = do_pop ? sp_q - 1'b1 : sp_q;
  assign do_wr  = push_i && (do_pop || (sp_q < DW'(NEST_MAX)));

  always_comb begin
    sp_d = sp_q;
    if (push_i && !do_pop && (sp_q < DW'(NEST_MAX))) sp_d = sp_q + 1'b1;
    else if (!push_i && do_pop)                      sp_d = sp_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
      for (int k = 0; k < NEST_MAX; k++) stk_q[k] <= '0;
    end else begin
      sp_q <= sp_d;
      for (int k = 0; k < NEST_MAX; k++) begin
        if (do_wr && (wr_ptr == DW'(k))) stk_q[k] <= push_idx_i;
      end
    end
  end

  // level in service: top entry, or N_SRC when nothing is in service
  always_comb begin
    lvl_o = IDX_W'(N_SRC);
    for (int k = 0; k < NEST_MAX; k++) begin
      if (sp_q == DW'(k + 1)) lvl_o = stk_q[k];
    end
  end

  assign depth_o = sp_q;

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int N_GP     = irq_nest_pkg::GP_PINS_DEF,
  parameter int N_INTL   = irq_nest_pkg::INTL_SRC_DEF,
  parameter int NEST_MAX = N_GP + 1 + N_INTL,
  localparam int N_EXT = N_GP + 1,
  localparam int N_SRC = N_EXT + N_INTL,
  localparam int IDX_W = $clog2(N_SRC + 1),
  localparam int DW    = $clog2(NEST_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [N_SRC-1:0]  cfg_en_i,
  input  logic [N_GP-1:0]   cfg_rise_i,
  input  logic [N_EXT-1:0]  ext_pin_i,
  input  logic [N_INTL-1:0] intl_evt_i,
  input  logic              rti_i,
  output logic              irq_valid_o,
  output logic [IDX_W-1:0]  irq_idx_o,
  input  logic              irq_ready_i,
  output logic [N_SRC-1:0]  pend_o
);

  logic [N_SRC-1:0] en_q;
  logic [N_GP-1:0]  rise_q;
  logic [N_EXT-1:0] ext_edge;
  logic [N_SRC-1:0] set_vec;
  logic [N_SRC-1:0] pend;
  logic [IDX_W-1:0] cur_lvl;
  logic [DW-1:0]    depth;
  logic             accept;

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      rise_q <= '0;
    end else if (cfg_wr_i) begin
      en_q   <= cfg_en_i;
      rise_q <= cfg_rise_i;
    end
  end

  irq_edge_det #(.N_GP(N_GP)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (ext_pin_i),
    .rise_sel_i (rise_q),
    .edge_o     (ext_edge)
  );

  // external sources take the low (urgent) indices
  assign set_vec = {intl_evt_i, ext_edge};

  irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .en_i      (en_q),
    .clr_vld_i (accept),
    .clr_idx_i (irq_idx_o),
    .pend_o    (pend)
  );

  irq_issue #(.N_SRC(N_SRC)) u_issue (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_i   (pend),
    .en_i     (en_q),
    .lvl_i    (cur_lvl),
    .ready_i  (irq_ready_i),
    .valid_o  (irq_valid_o),
    .idx_o    (irq_idx_o),
    .accept_o (accept)
  );

  irq_nest_stack #(.N_SRC(N_SRC), .NEST_MAX(NEST_MAX)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (accept),
    .push_idx_i (irq_idx_o),
    .pop_i      (rti_i),
    .lvl_o      (cur_lvl),
    .depth_o    (depth)
  );

  assign pend_o = pend;

endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
  parameter int N_SRC    = 14,
  parameter int NEST_MAX = 14,
  localparam int IDX_W = $clog2(N_SRC + 1),
  localparam int DW    = $clog2(NEST_MAX + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_valid_i,
  input logic [IDX_W-1:0] irq_idx_i,
  input logic             irq_ready_i,
  input logic             rti_i,
  input logic [IDX_W-1:0] lvl_i,
  input logic [DW-1:0]    depth_i
);

  p_hold_offer_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_i && !irq_ready_i) |=> (irq_valid_i && (irq_idx_i == $past(irq_idx_i))));

  p_gap_after_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_i && irq_ready_i) |=> !irq_valid_i);

  p_above_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_i |-> (irq_idx_i < lvl_i));

  p_push_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_i && irq_ready_i && !rti_i) |=> (depth_i == $past(depth_i) + 1'b1));

  p_pop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rti_i && !(irq_valid_i && irq_ready_i) && (depth_i != '0)) |=> (depth_i == $past(depth_i) - 1'b1));

  p_empty_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_i == '0) |-> (lvl_i == IDX_W'(N_SRC)));

  p_replace_top_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_i && irq_ready_i && rti_i && (depth_i != '0)) |=> (depth_i == $past(depth_i)));

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_i <= DW'(NEST_MAX));

endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.N_SRC(N_SRC), .NEST_MAX(NEST_MAX)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_valid_i (irq_valid_o),
  .irq_idx_i   (irq_idx_o),
  .irq_ready_i (irq_ready_i),
  .rti_i       (rti_i),
  .lvl_i       (cur_lvl),
  .depth_i     (depth)
);

// File: tb/irq_nest_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_nest_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [13:0] cfg_en;
  logic [5:0]  cfg_rise;
  logic [6:0]  pins;
  logic [6:0]  evt;
  logic        rti;
  logic        ready;
  logic        irq_valid;
  logic [3:0]  irq_idx;
  logic [13:0] pend;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  irq_nest_ctrl dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_wr_i    (cfg_wr),
    .cfg_en_i    (cfg_en),
    .cfg_rise_i  (cfg_rise),
    .ext_pin_i   (pins),
    .intl_evt_i  (evt),
    .rti_i       (rti),
    .irq_valid_o (irq_valid),
    .irq_idx_o   (irq_idx),
    .irq_ready_i (ready),
    .pend_o      (pend)
  );

  // reference model state, built from the requirements
  logic [6:0]  m_s1, m_s2, m_s3;
  logic [13:0] m_en, m_pend;
  logic [5:0]  m_rise;
  logic        m_v;
  int          m_idx;
  int          m_stk [16];
  int          m_sp;

  function automatic int m_level();
    return (m_sp == 0) ? 14 : m_stk[m_sp-1];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_s1 = '0; m_s2 = '0; m_s3 = '0;
    m_en = '0; m_rise = '0; m_pend = '0;
    m_v = 1'b0; m_idx = 0; m_sp = 0;
    for (int k = 0; k < 16; k++) m_stk[k] = 0;
  endtask

  task automatic compare();
    chk("R6", {31'd0, irq_valid}, {31'd0, m_v});
    if (m_v) chk("R1", {28'd0, irq_idx}, m_idx);
    chk("R5", {18'd0, pend}, {18'd0, m_pend});
  endtask

  // one clock: compute model next state from the current inputs, then compare
  task automatic step(input int n);
    for (int c = 0; c < n; c++) begin
      logic [6:0]  e;
      logic [13:0] setv, clrm, cand, n_pend;
      logic        acc, n_v;
      int          best, n_idx, lvl;
      if (!rst_n) begin
        @(posedge clk);
        model_reset();
      end else begin
        e[0] = m_s3[0] & ~m_s2[0];
        for (int g = 1; g < 7; g++)
          e[g] = m_rise[g-1] ? (m_s2[g] & ~m_s3[g]) : (m_s3[g] & ~m_s2[g]);
        setv = {evt, e};
        acc  = m_v && ready;
        clrm = acc ? (14'd1 << m_idx) : 14'd0;
        n_pend = (m_pend & ~clrm) | (setv & m_en);
        lvl = m_level();
        cand = '0;
        best = 0;
        for (int i = 0; i < 14; i++) cand[i] = m_pend[i] & m_en[i] & (i < lvl);
        for (int i = 13; i >= 0; i--) if (cand[i]) best = i;
        n_v = m_v; n_idx = m_idx;
        if (!m_v) begin n_v = |cand; if (|cand) n_idx = best; end
        else if (acc) n_v = 1'b0;
        @(posedge clk);
        if (acc && rti && m_sp > 0) m_stk[m_sp-1] = m_idx;
        else begin
          if (acc && m_sp < 14) begin m_stk[m_sp] = m_idx; m_sp++; end
          if (rti && !acc && m_sp > 0) m_sp--;
        end
        if (cfg_wr) begin m_en = cfg_en; m_rise = cfg_rise; end
        m_pend = n_pend; m_v = n_v; m_idx = n_idx;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = pins;
      end
      @(negedge clk);
      compare();
    end
  endtask

  task automatic accept();
    ready = 1'b1; step(1); ready = 1'b0;
  endtask

  task automatic ret();
    rti = 1'b1; step(1); rti = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] bits);
    evt = bits; step(1); evt = '0;
  endtask

  task automatic config_wr(input logic [13:0] en, input logic [5:0] rise);
    cfg_en = en; cfg_rise = rise; cfg_wr = 1'b1; step(1); cfg_wr = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #2_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog (R1..R10 run): actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_en = '0; cfg_rise = '0;
    pins = 7'b0000001; evt = '0; rti = 1'b0; ready = 1'b0;
    model_reset();
    @(negedge clk);
    step(3);
    rst_n = 1'b1;
    // R8: state right after reset
    chk("R8", {31'd0, irq_valid}, 0);
    chk("R8", {18'd0, pend}, 0);
    step(2);

    config_wr(14'h3FFF, 6'b000001);
    step(3);

    // R5 / R2: GP0 rising edge through the synchronizer
    pins[1] = 1'b1;
    step(2);
    chk("R5", {31'd0, pend[1]}, 0);
    step(1);
    chk("R5", {31'd0, pend[1]}, 1);
    step(1);
    chk("R1", {28'd0, irq_idx}, 1);
    accept();
    chk("R7", {31'd0, irq_valid}, 0);
    chk("R7", {31'd0, pend[1]}, 0);

    // R6: timer 0 blocked below the level in service
    pulse(7'b0001000);
    step(3);
    chk("R6", {31'd0, pend[10]}, 1);
    chk("R6", {31'd0, irq_valid}, 0);

    // R3: power-monitor falling edge pre-empts
    pins[0] = 1'b0;
    step(4);
    chk("R3", {31'd0, irq_valid}, 1);
    chk("R3", {28'd0, irq_idx}, 0);
    accept();
    ret();
    ret();
    step(1);
    chk("R6", {28'd0, irq_idx}, 10);
    accept();
    ret();
    ret();                              // empty stack: ignored
    pulse(7'b0000001);
    step(1);
    chk("R6", {28'd0, irq_idx}, 7);
    accept();
    pulse(7'b0001000);
    step(3);
    chk("R6", {31'd0, irq_valid}, 0);   // level 7 survived the empty return
    ret();
    step(1);
    chk("R6", {28'd0, irq_idx}, 10);
    accept();
    ret();

    // R3: rising edge of the power-monitor pin ignored
    pins[0] = 1'b1;
    step(6);
    chk("R3", {31'd0, pend[0]}, 0);
    chk("R3", {31'd0, irq_valid}, 0);

    // R2: GP1 set to falling
    pins[2] = 1'b1;
    step(5);
    chk("R2", {31'd0, pend[2]}, 0);
    pins[2] = 1'b0;
    step(3);
    chk("R2", {31'd0, pend[2]}, 1);
    step(1);
    chk("R2", {28'd0, irq_idx}, 2);
    accept();
    ret();
    pins[1] = 1'b0;                     // GP0 is rising-only
    step(5);
    chk("R2", {31'd0, pend[1]}, 0);

    // R4: disabled source does not latch
    config_wr(14'h3FF7, 6'b000001);
    pins[3] = 1'b1;
    step(4);
    pins[3] = 1'b0;
    step(5);
    chk("R4", {31'd0, pend[3]}, 0);
    config_wr(14'h3FFF, 6'b000001);
    step(1);

    // R1: three internal sources at once
    pulse(7'b0010110);
    step(1);
    chk("R1", {28'd0, irq_idx}, 8);
    accept();
    step(3);
    chk("R6", {31'd0, irq_valid}, 0);
    ret();
    step(1);
    chk("R1", {28'd0, irq_idx}, 9);
    accept();
    ret();
    step(1);
    chk("R1", {28'd0, irq_idx}, 11);
    accept();
    ret();

    // R7: open offer stays put while a more urgent one arrives
    pulse(7'b0000100);
    step(1);
    chk("R7", {28'd0, irq_idx}, 9);
    pulse(7'b0000001);
    step(2);
    chk("R7", {31'd0, irq_valid}, 1);
    chk("R7", {28'd0, irq_idx}, 9);
    accept();
    step(1);
    chk("R6", {28'd0, irq_idx}, 7);
    accept();

    // R10: acceptance and return in the same cycle
    pins[0] = 1'b0;
    step(4);
    chk("R10", {28'd0, irq_idx}, 0);
    ready = 1'b1; rti = 1'b1; step(1); ready = 1'b0; rti = 1'b0;
    ret();
    pulse(7'b0000010);
    step(1);
    chk("R10", {31'd0, irq_valid}, 1);
    chk("R10", {28'd0, irq_idx}, 8);
    accept();
    ret();
    ret();
    step(2);

    // random phase against the reference model
    for (int r = 0; r < 3000; r++) begin
      for (int b = 0; b < 7; b++) evt[b] = (($urandom % 8) == 0);
      ready = $urandom % 2;
      rti = (($urandom % 10) == 0);
      if (($urandom % 40) == 0) pins[$urandom % 7] ^= 1'b1;
      cfg_wr = (($urandom % 60) == 0);
      cfg_en = (($urandom % 4) == 0) ? 14'($urandom) : 14'h3FFF;
      cfg_rise = 6'($urandom);
      step(1);
    end
    evt = '0; ready = 1'b0; rti = 1'b0; cfg_wr = 1'b0;
    step(2);

    // R8: reset mid-run
    pulse(7'h7F);
    step(1);
    rst_n = 1'b0;
    pins = 7'b0000001;
    step(1);
    chk("R8", {18'd0, pend}, 0);
    chk("R8", {31'd0, irq_valid}, 0);
    rst_n = 1'b1;
    step(5);
    pulse(7'b0000001);
    step(1);
    chk("R8", {31'd0, pend[7]}, 0);     // enables cleared by reset

    // R9: fourteen nested levels
    config_wr(14'h3FFF, 6'b111111);
    step(2);
    for (int s = 13; s >= 7; s--) begin
      pulse(7'(1 << (s - 7)));
      step(1);
      chk("R9", {28'd0, irq_idx}, s);
      accept();
    end
    for (int g = 6; g >= 1; g--) begin
      pins[g] = 1'b1;
      step(4);
      chk("R9", {28'd0, irq_idx}, g);
      accept();
    end
    pins[0] = 1'b0;
    step(4);
    chk("R9", {28'd0, irq_idx}, 0);
    accept();
    pulse(7'h7F);
    step(3);
    chk("R9", {31'd0, irq_valid}, 0);
    for (int k = 0; k < 7; k++) ret();
    step(2);
    chk("R9", {31'd0, irq_valid}, 0);
    ret();
    step(1);
    chk("R9", {28'd0, irq_idx}, 7);

    summary();
    $finish;
  end

endmodule